// File: doc/BRIEF.md
# Carry Chain Length Analyzer

This block inspects a pair of N-bit addition operands and works out how far carries travel in their sum. At every bit position where both operand bits are 1, a carry is created. That carry rides upward through each following bit where exactly one operand bit is 1. The run of positions from the creating bit to the last bit it crosses is one carry chain. A single operand pair can hold several such chains. The block finds the longest one and reports three things about it: its length, which serves as the weight of the pair, and its lowest and highest bit indices. It also reports how many chains the pair contains.

The weight ranks operand pairs by how close their carry path comes to the full adder width. Pairs with equal weight belong to the same category. A caller presents a pair with a one-cycle `in_valid` strobe. One clock later, a one-cycle `out_valid` strobe appears together with the registered results, and those results stay unchanged until the next strobe. There is no back-pressure.

Top module: `carry_chain_analyzer`

## Requirements
- R1: While `rst_n` is low at a clock edge, `out_valid`, `out_weight`, `out_start`, `out_finish` and `out_count` are all 0 after that edge.
- R2: `out_valid` is 1 in exactly the cycles that follow a clock edge at which `in_valid` was 1 and reset was not active.
- R3: `out_weight` equals the length, counted in bit positions, of the longest carry chain of the operands captured with the last `in_valid`.
- R4: `out_start` is the index of the generate bit (both operand bits 1) that begins the reported chain, and `out_finish` equals `out_start + out_weight - 1`.
- R5: A chain extends upward only through bits where exactly one operand bit is 1. It ends below the next bit where both operand bits are 0 or both are 1, or at bit N-1.
- R6: When several chains share the maximum length, the chain with the lowest start index is reported.
- R7: When no bit has both operand bits set, `out_weight`, `out_start`, `out_finish` and `out_count` are all 0.
- R8: `out_count` equals the number of bit positions where both operand bits are 1, since each of them begins one chain.
- R9: In cycles where `in_valid` was 0 at the preceding edge, the four result outputs keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Strobe: capture `in_a`/`in_b` at this edge |
| in_a | input | N | First operand |
| in_b | input | N | Second operand |
| out_valid | output | 1 | One-cycle strobe marking fresh results |
| out_weight | output | clog2(N+1) | Length of the longest chain (0 if there is none) |
| out_start | output | clog2(N) | Lowest bit index of the reported chain |
| out_finish | output | clog2(N) | Highest bit index of the reported chain |
| out_count | output | clog2(N+1) | Number of chains in the pair |

## Verification
The bound checker checks on every cycle the properties that hold whatever the operand values are:
- the strobe timing and the reset clearing;
- that results stay put between strobes;
- that finish, start and weight agree, and that the chain stays inside the operand width;
- that weight and count are either both zero or both non-zero.

Whether the weight is the true maximum, whether ties go to the lowest start, and whether a chain stops at a kill or at a fresh generate bit all depend on the operand values. Only the bench's scenarios can show these. They are checked against an independent bit-walk model over directed patterns and a few hundred random pairs.

// File: rtl/ccl_pkg.sv
// Shared types for the carry chain length analyzer.
// Assumes nothing beyond a two-operand binary sum.
package ccl_pkg;
    // Role a single bit position plays in carry movement.
    typedef enum logic [1:0] {
        BC_KILL = 2'd0,  // both operand bits 0: an incoming carry dies here
        BC_PROP = 2'd1,  // exactly one operand bit 1: an incoming carry passes through
        BC_GEN  = 2'd2   // both operand bits 1: a new carry is created here
    } bit_cls_e;
endpackage

// File: rtl/ccl_bit_class.sv
// Classifies each operand bit position as kill, propagate or generate.
// It then exposes the generate and propagate vectors.
// Assumes the two operands have equal width N. Purely combinational.
module ccl_bit_class
    import ccl_pkg::*;
#(
    parameter int N = 16
) (
    input  logic [N-1:0] op_a,
    input  logic [N-1:0] op_b,
    output logic [N-1:0] gen,
    output logic [N-1:0] prop
);
    bit_cls_e cls [N];

    for (genvar i = 0; i < N; i++) begin : g_bit
        // Decide the role of bit i.
        always_comb begin
            if (op_a[i] & op_b[i])      cls[i] = BC_GEN;
            else if (op_a[i] ^ op_b[i]) cls[i] = BC_PROP;
            else                        cls[i] = BC_KILL;
        end
        assign gen[i]  = (cls[i] == BC_GEN);
        assign prop[i] = (cls[i] == BC_PROP);
    end
endmodule

// File: rtl/ccl_run_scan.sv
// For every bit position, gives the length of the chain that starts there.
// The length is 1 plus the unbroken run of propagate bits directly above,
// or 0 where the bit does not generate.
// Assumes gen and prop are never both set on one bit. Combinational.
module ccl_run_scan #(
    parameter int N  = 16,
    parameter int LW = $clog2(N + 1)
) (
    input  logic [N-1:0]          gen,
    input  logic [N-1:0]          prop,
    output logic [N-1:0][LW-1:0]  chain_len
);
    // prun[i]: number of consecutive propagate bits starting at bit i upward.
    logic [N-1:0][LW-1:0] prun;

    for (genvar i = N - 1; i >= 0; i--) begin : g_scan
        if (i == N - 1) begin : g_top
            // The top bit has nothing above it.
            assign prun[i]      = prop[i] ? LW'(1) : '0;
            assign chain_len[i] = gen[i] ? LW'(1) : '0;
        end else begin : g_mid
            // Extend the propagate run from the bit above.
            assign prun[i]      = prop[i] ? prun[i+1] + LW'(1) : '0;
            // A chain starting here crosses the whole run above it.
            assign chain_len[i] = gen[i] ? prun[i+1] + LW'(1) : '0;
        end
    end
endmodule

// File: rtl/ccl_max_select.sv
// Selects the longest chain length and its start index, and tallies chains.
// Ties resolve to the lowest index, because only a strictly greater length
// replaces the current best during an ascending scan.
// Assumes chain_len is 0 wherever gen is 0. Combinational.
module ccl_max_select #(
    parameter int N  = 16,
    parameter int LW = $clog2(N + 1),
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]          gen,
    input  logic [N-1:0][LW-1:0]  chain_len,
    output logic [LW-1:0]         best_len,
    output logic [IW-1:0]         best_idx,
    output logic [LW-1:0]         num_chains
);
    // Ascending scan with strict comparison: the lowest start wins ties.
    always_comb begin
        best_len = '0;
        best_idx = '0;
        for (int i = 0; i < N; i++) begin
            if (chain_len[i] > best_len) begin
                best_len = chain_len[i];
                best_idx = IW'(i);
            end
        end
    end

    // Population count of the generate bits, one chain per bit.
    always_comb begin
        num_chains = '0;
        for (int i = 0; i < N; i++) begin
            num_chains = num_chains + LW'(gen[i]);
        end
    end
endmodule

// File: rtl/carry_chain_analyzer.sv
// Top of the carry chain length analyzer.
// On an in_valid strobe it registers the longest chain's weight, start and
// finish, plus the chain count, and pulses out_valid for one cycle.
// Assumes a synchronous active-low reset and no back-pressure.
module carry_chain_analyzer #(
    parameter  int N  = 16,
    localparam int LW = $clog2(N + 1),
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [N-1:0]  in_a,
    input  logic [N-1:0]  in_b,
    output logic          out_valid,
    output logic [LW-1:0] out_weight,
    output logic [IW-1:0] out_start,
    output logic [IW-1:0] out_finish,
    output logic [LW-1:0] out_count
);
    logic [N-1:0]         gen;
    logic [N-1:0]         prop;
    logic [N-1:0][LW-1:0] chain_len;
    logic [LW-1:0]        best_len;
    logic [IW-1:0]        best_idx;
    logic [LW-1:0]        num_chains;
    logic [LW-1:0]        fin_wide;
    logic [IW-1:0]        best_fin;

    ccl_bit_class #(.N(N)) u_class (
        .op_a (in_a),
        .op_b (in_b),
        .gen  (gen),
        .prop (prop)
    );

    ccl_run_scan #(.N(N), .LW(LW)) u_scan (
        .gen       (gen),
        .prop      (prop),
        .chain_len (chain_len)
    );

    ccl_max_select #(.N(N), .LW(LW), .IW(IW)) u_select (
        .gen        (gen),
        .chain_len  (chain_len),
        .best_len   (best_len),
        .best_idx   (best_idx),
        .num_chains (num_chains)
    );

    // Finish index of the winning chain; 0 when there is no chain.
    always_comb begin
        fin_wide = LW'(best_idx) + best_len - LW'(1);
        best_fin = (best_len == '0) ? '0 : fin_wide[IW-1:0];
    end

    // Strobe register: one pulse per accepted operand pair.
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= in_valid;
    end

    // Result registers: load on a strobe, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_weight <= '0;
            out_start  <= '0;
            out_finish <= '0;
            out_count  <= '0;
        end else if (in_valid) begin
            out_weight <= best_len;
            out_start  <= best_idx;
            out_finish <= best_fin;
            out_count  <= num_chains;
        end
    end
endmodule

// File: rtl/ccl_checker.sv
// Cycle-by-cycle properties of carry_chain_analyzer, attached with bind.
// Assumes the same N as the checked instance.
module ccl_checker #(
    parameter  int N  = 16,
    localparam int LW = $clog2(N + 1),
    localparam int IW = $clog2(N)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic          out_valid,
    input logic [LW-1:0] out_weight,
    input logic [IW-1:0] out_start,
    input logic [IW-1:0] out_finish,
    input logic [LW-1:0] out_count
);
    // R1: reset clears the strobe and every result.
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_weight == '0 && out_start == '0 &&
                    out_finish == '0 && out_count == '0));

    // R2: a strobe in gives a strobe out one cycle later.
    a_r2_strobe_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R2: no strobe out without a strobe in.
    a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R4: finish sits weight-1 positions above start.
    a_r4_span_matches: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_weight != '0) |->
            ((LW + 1)'(out_finish) == (LW + 1)'(out_start) + (LW + 1)'(out_weight) - (LW + 1)'(1)));

    // R5: a reported chain never runs past the top bit.
    a_r5_within_width: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((LW + 1)'(out_start) + (LW + 1)'(out_weight) <= (LW + 1)'(N)));

    // R7 / R8: weight and count are zero together.
    a_r7_zero_together: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((out_count == '0) == (out_weight == '0)));

    // R7: no chain means start and finish are 0.
    a_r7_empty_indices: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_count == '0) |-> (out_start == '0 && out_finish == '0));

    // R9: results hold between strobes.
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_weight) && $stable(out_start) &&
                       $stable(out_finish) && $stable(out_count)));
endmodule

bind carry_chain_analyzer ccl_checker #(.N(N)) u_ccl_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .out_valid  (out_valid),
    .out_weight (out_weight),
    .out_start  (out_start),
    .out_finish (out_finish),
    .out_count  (out_count)
);

// File: tb/carry_chain_analyzer_test.sv
`timescale 1ns/1ps
module carry_chain_analyzer_test;
    localparam int N  = 16;
    localparam int LW = $clog2(N + 1);
    localparam int IW = $clog2(N);

    typedef struct {
        int    weight;
        int    start;
        int    finish;
        int    count;
        string tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [N-1:0]  in_a = '0;
    logic [N-1:0]  in_b = '0;
    logic          out_valid;
    logic [LW-1:0] out_weight;
    logic [IW-1:0] out_start;
    logic [IW-1:0] out_finish;
    logic [LW-1:0] out_count;

    int   n_checks = 0;
    int   n_fails  = 0;
    bit   mon_en   = 1'b0;
    bit   done     = 1'b0;
    logic exp_v    = 1'b0;
    exp_t q[$];
    exp_t last;
    string hold_tag = "R1";

    always #2 clk = ~clk;

    carry_chain_analyzer #(.N(N)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
        .out_valid(out_valid), .out_weight(out_weight), .out_start(out_start),
        .out_finish(out_finish), .out_count(out_count)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Independent model: walk upward from each generate bit.
    function automatic exp_t model(input logic [N-1:0] a, input logic [N-1:0] b, input string tag);
        exp_t e;
        e.weight = 0; e.start = 0; e.finish = 0; e.count = 0; e.tag = tag;
        for (int s = 0; s < N; s++) begin
            if (a[s] && b[s]) begin
                int f = s;
                e.count++;
                while (f + 1 < N && (a[f+1] != b[f+1])) f++;
                if (f - s + 1 > e.weight) begin
                    e.weight = f - s + 1; e.start = s; e.finish = f;
                end
            end
        end
        return e;
    endfunction

    // Driver: present a pair for one cycle and queue its expected result.
    task automatic send(input logic [N-1:0] a, input logic [N-1:0] b, input string tag);
        @(negedge clk);
        in_a = a; in_b = b; in_valid = 1'b1;
        q.push_back(model(a, b, tag));
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (n - 1) @(negedge clk);
    endtask

    // Reference strobe timing for R2.
    always @(posedge clk) exp_v <= rst_n ? in_valid : 1'b0;

    // Monitor: compare results away from the active edge.
    always @(negedge clk) begin
        if (mon_en) begin
            chk("R2 out_valid", int'(out_valid), int'(exp_v));
            if (out_valid) begin
                if (q.size() == 0) begin
                    chk("R2 unexpected result", 1, 0);
                end else begin
                    last = q.pop_front();
                    chk({last.tag, " R3 weight"}, int'(out_weight), last.weight);
                    chk({last.tag, " R4 start"},  int'(out_start),  last.start);
                    chk({last.tag, " R4 finish"}, int'(out_finish), last.finish);
                    chk({last.tag, " R8 count"},  int'(out_count),  last.count);
                    hold_tag = "R9";
                end
            end else begin
                chk({hold_tag, " weight"}, int'(out_weight), last.weight);
                chk({hold_tag, " start"},  int'(out_start),  last.start);
                chk({hold_tag, " finish"}, int'(out_finish), last.finish);
                chk({hold_tag, " count"},  int'(out_count),  last.count);
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    end

    initial begin
        last.weight = 0; last.start = 0; last.finish = 0; last.count = 0; last.tag = "R1";
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        mon_en = 1'b1;                    // R1 reset state checked by idle compares
        idle(2);
        send(16'h0000, 16'h0000, "R7 zero");          // no chain
        send(16'hFFFF, 16'h0000, "R7 allprop");       // propagate only
        idle(3);                                       // R9 hold
        send(16'h0001, 16'h0001, "R3 single");        // weight 1 at bit 0
        send(16'h0001, 16'hFFFF, "R5 topbit");        // gen 0, prop 1..15: weight 16
        send(16'hFFFF, 16'hFFFF, "R5 regen");         // 16 chains, each length 1
        send(16'h00F1, 16'h0001, "R5 kill");          // prop 4..7 not adjacent to gen 0
        send(16'h0F01, 16'h010F, "R6 tie");           // chains 0..3 and 8..11: start 0
        send(16'h8000, 16'h8000, "R3 msb");           // gen at bit 15 only
        send(16'h0C03, 16'h0401, "R6 tie2");          // gen 0 +1, gen 10 +1: start 0
        idle(4);
        for (int k = 0; k < 300; k++) begin
            send(N'($urandom), N'($urandom), "R3 random");
            if (k % 7 == 0) idle(2);
        end
        idle(5);
        chk("R2 queue drained", q.size(), 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end
endmodule